// File: doc/BRIEF.md
# Pipelined CORDIC Phase Rotator with Selectable Output Gain

This block turns a stream of complex samples through an angle that arrives with each sample, as the mixing stage of a digital downconverter does. Each input beat carries a signed in-phase word, a signed quadrature word, an unsigned phase word and a gain-mode bit. The block returns the rotated pair at the same width after a fixed number of pipeline stages. The angle is `in_phase * 2*pi / 2^PW` and the rotation is counter-clockwise. A downconverter supplies the negated oscillator phase. Vector rotation multiplies the magnitude by about 1.6468, and this gain is kept and not corrected.

The top two phase bits choose a ±90 degree pre-rotation, so every angle on the circle converges. Sixteen shift-and-add stages follow, with an internal datapath that carries two guard bits and four fraction bits. The output stage has two gain settings. It can halve the result, so that a 16376-peak input gives about 13484. Or it can drop the halving, which doubles the amplitude (about 6 dB). Results are rounded to nearest and clamped to ±(2^(DW-1)-1). A vector whose components are both large can grow by up to root-two when rotated, and in that case the output clamps instead of wrapping around.

Both stream sides use valid/ready. A beat moves when valid and ready are both high at a rising edge. The whole pipeline advances only when its output register is empty or is being taken. So `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds its value and no new beat is accepted. A producer may hold `in_valid` for as long as it likes, and the rotator never drops or repeats a beat.

Top module: `cordic_rotator`

## Requirements
- R1: With `gain_full`=0, each output pair equals K·(I·cosθ − Q·sinθ)/2 and K·(I·sinθ + Q·cosθ)/2. Here θ = in_phase·2π/65536 and K is the product over i=0..15 of sqrt(1+2^-2i), about 1.64676. The result is rounded and clamped, and may differ from this value by at most 4 LSB.
- R2: With `gain_full`=1 the same formula applies without the division by 2, within 4 LSB.
- R3: A result beyond the 16-bit range clamps to +32767 or −32767. The value −32768 is never produced.
- R4: All four quadrants selected by in_phase[15:14] (00, 01, 10, 11) rotate correctly, including angles of exactly 90, 180 and 270 degrees.
- R5: The output is rounded to nearest, not truncated. An all-zero input gives exactly 0 at any phase. Over many random samples, the mean error of the output against the ideal real value is within ±0.25 LSB.
- R6: Stream rules: `in_ready` = !out_valid || out_ready. The output holds stable while out_valid=1 and out_ready=0. Beats come out in order, each exactly once.
- R7: With `out_ready` held high, a beat accepted on edge n is first shown on the outputs after edge n+17 (ITER+1).
- R8: The gain mode is captured with each accepted beat. Changing `gain_full` between beats does not affect beats already inside the pipeline.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Rotator can take a beat |
| in_i | input | DW (16) | Signed in-phase input |
| in_q | input | DW (16) | Signed quadrature input |
| in_phase | input | PW (16) | Unsigned rotation angle, full circle = 2^PW |
| gain_full | input | 1 | 1: no output halving; 0: output halved |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_i | output | DW (16) | Rotated signed in-phase output |
| out_q | output | DW (16) | Rotated signed quadrature output |

## Verification
- Exact-quadrant angles with a lone I or Q component show whether the pre-rotation picks the right sign and axis.
- 45-degree angles with equal large components tell the root-two growth apart. It clamps in full-gain mode and stays in range in halving mode, and a swap of the two modes would show.
- A full-scale 16376 input at angle zero pins the halving factor. An all-zero input and the mean error over a batch of random samples tell rounding apart from truncation.
- Random back-pressure on `out_ready`, with the mode flipping beat by beat, checks ordering, holding and per-beat mode capture. An unstalled single beat measures the latency.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int ZW = 32;  // internal angle width, full circle = 2^ZW

  // arctangent of 2^-k in units of 2^ZW per full turn
  function automatic logic [ZW-1:0] atan_step(input int k);
    case (k)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      default: return 32'(32'd683565276 >> k);
    endcase
  endfunction
endpackage

// File: rtl/rot_entry.sv
module rot_entry #(
  parameter int DW   = 16,
  parameter int PW   = 16,
  parameter int IW   = 22,
  parameter int FRAC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     v_i,
  input  logic signed [DW-1:0]     i_i,
  input  logic signed [DW-1:0]     q_i,
  input  logic [PW-1:0]            ph_i,
  input  logic                     mode_i,
  output logic                     v_o,
  output logic signed [IW-1:0]     x_o,
  output logic signed [IW-1:0]     y_o,
  output logic [rot_pkg::ZW-1:0]   z_o,
  output logic                     mode_o
);
  localparam int ZW = rot_pkg::ZW;
  localparam logic [ZW-1:0] QUARTER = ZW'(1) << (ZW-2);

  logic signed [IW-1:0] xe, ye, xn, yn;
  logic [ZW-1:0]        ze, zn;

  always_comb begin
    xe = {{(IW-DW){i_i[DW-1]}}, i_i} <<< FRAC;
    ye = {{(IW-DW){q_i[DW-1]}}, q_i} <<< FRAC;
    ze = ZW'(ph_i) << (ZW-PW);
    unique case (ph_i[PW-1:PW-2])
      2'b01: begin xn = -ye; yn = xe;  zn = ze - QUARTER; end  // +90
      2'b10: begin xn = ye;  yn = -xe; zn = ze + QUARTER; end  // -90
      default: begin xn = xe; yn = ye; zn = ze; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   v_o <= 1'b0;
    else if (adv) v_o <= v_i;
    if (adv) begin
      x_o <= xn; y_o <= yn; z_o <= zn; mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/rot_step.sv
module rot_step #(
  parameter int IW    = 22,
  parameter int SHIFT = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     v_i,
  input  logic signed [IW-1:0]     x_i,
  input  logic signed [IW-1:0]     y_i,
  input  logic [rot_pkg::ZW-1:0]   z_i,
  input  logic                     mode_i,
  output logic                     v_o,
  output logic signed [IW-1:0]     x_o,
  output logic signed [IW-1:0]     y_o,
  output logic [rot_pkg::ZW-1:0]   z_o,
  output logic                     mode_o
);
  localparam int ZW = rot_pkg::ZW;
  localparam logic [ZW-1:0] ANG = rot_pkg::atan_step(SHIFT);

  logic signed [IW-1:0] dx, dy, xn, yn;
  logic [ZW-1:0]        zn;

  always_comb begin
    dx = x_i >>> SHIFT;
    dy = y_i >>> SHIFT;
    if (!z_i[ZW-1]) begin
      xn = x_i - dy; yn = y_i + dx; zn = z_i - ANG;
    end else begin
      xn = x_i + dy; yn = y_i - dx; zn = z_i + ANG;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   v_o <= 1'b0;
    else if (adv) v_o <= v_i;
    if (adv) begin
      x_o <= xn; y_o <= yn; z_o <= zn; mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/rot_scale.sv
module rot_scale #(
  parameter int DW   = 16,
  parameter int IW   = 22,
  parameter int FRAC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  v_i,
  input  logic signed [IW-1:0]  x_i,
  input  logic signed [IW-1:0]  y_i,
  input  logic                  full_i,
  output logic                  v_o,
  output logic signed [DW-1:0]  i_o,
  output logic signed [DW-1:0]  q_o
);
  localparam logic signed [IW:0] HI = (IW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [IW:0] LO = -HI;
  localparam logic signed [IW:0] HALF_F = (IW+1)'(1 << (FRAC-1));
  localparam logic signed [IW:0] HALF_H = (IW+1)'(1 << FRAC);

  function automatic logic signed [DW-1:0] shape(input logic signed [IW-1:0] v,
                                                 input logic full);
    logic signed [IW:0] e, r;
    e = {v[IW-1], v};
    if (full) r = (e + HALF_F) >>> FRAC;
    else      r = (e + HALF_H) >>> (FRAC + 1);
    if (r > HI)      r = HI;
    else if (r < LO) r = LO;
    return r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   v_o <= 1'b0;
    else if (adv) v_o <= v_i;
    if (adv) begin
      i_o <= shape(x_i, full_i);
      q_o <= shape(y_i, full_i);
    end
  end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int DW    = 16,
  parameter int PW    = 16,
  parameter int ITER  = 16,
  parameter int GUARD = 2,
  parameter int FRAC  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [PW-1:0]        in_phase,
  input  logic                 gain_full,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int IW = DW + GUARD + FRAC;
  localparam int ZW = rot_pkg::ZW;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic                 sv [ITER+1];
  logic                 sm [ITER+1];
  logic signed [IW-1:0] sx [ITER+1];
  logic signed [IW-1:0] sy [ITER+1];
  logic [ZW-1:0]        sz [ITER+1];

  rot_entry #(.DW(DW), .PW(PW), .IW(IW), .FRAC(FRAC)) u_entry (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .v_i(in_valid), .i_i(in_i), .q_i(in_q), .ph_i(in_phase), .mode_i(gain_full),
    .v_o(sv[0]), .x_o(sx[0]), .y_o(sy[0]), .z_o(sz[0]), .mode_o(sm[0])
  );

  for (genvar k = 0; k < ITER; k++) begin : g_step
    rot_step #(.IW(IW), .SHIFT(k)) u_step (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .v_i(sv[k]), .x_i(sx[k]), .y_i(sy[k]), .z_i(sz[k]), .mode_i(sm[k]),
      .v_o(sv[k+1]), .x_o(sx[k+1]), .y_o(sy[k+1]), .z_o(sz[k+1]), .mode_o(sm[k+1])
    );
  end

  rot_scale #(.DW(DW), .IW(IW), .FRAC(FRAC)) u_scale (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .v_i(sv[ITER]), .x_i(sx[ITER]), .y_i(sy[ITER]), .full_i(sm[ITER]),
    .v_o(out_valid), .i_o(out_i), .q_o(out_q)
  );
endmodule

// File: rtl/rot_chk.sv
module rot_chk #(
  parameter int DW  = 16,
  parameter int LAT = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q
);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [7:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_no_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != MINV && out_q != MINV));

  assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (inflight != 8'd0));

  assert_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(LAT));
endmodule

bind cordic_rotator rot_chk #(.DW(DW), .LAT(ITER + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_cordic_rotator.sv
`timescale 1ns/1ps
module sim_cordic_rotator;
  localparam int DW = 16, PW = 16, ITER = 16, TOL = 4;
  localparam int MAXV = 32767;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, gain_full = 0, out_ready = 1;
  logic signed [DW-1:0] in_i = 0, in_q = 0, out_i, out_q;
  logic [PW-1:0] in_phase = 0;
  logic in_ready, out_valid;

  always #5 clk = ~clk;

  cordic_rotator u0 (.*);

  typedef struct {
    int    ei, eq;
    real   ri;
    string tag;
    int    acc;
    bit    exact, lat, bias;
  } item_t;
  item_t sb[$];

  int checks = 0, fails = 0, cyc = 0;
  bit stall_en = 0, done = 0;
  real kgain, bias_sum = 0.0;
  int  bias_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2 out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  function automatic int clampr(real v);
    int r;
    r = (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
    if (r > MAXV) r = MAXV;
    if (r < -MAXV) r = -MAXV;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(int i, int q, int ph, bit full, string tag,
                      bit exact = 0, bit lat = 0, bit bias = 0);
    item_t it;
    real th, ri, rq, dv;
    th = real'(ph) * 2.0 * 3.14159265358979 / 65536.0;
    dv = full ? 1.0 : 2.0;
    ri = kgain * (real'(i) * $cos(th) - real'(q) * $sin(th)) / dv;
    rq = kgain * (real'(i) * $sin(th) + real'(q) * $cos(th)) / dv;
    @(negedge clk);
    in_valid = 1; in_i = DW'(i); in_q = DW'(q); in_phase = PW'(ph); gain_full = full;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    it.ei = clampr(ri); it.eq = clampr(rq); it.ri = ri; it.tag = tag;
    it.acc = cyc + 1; it.exact = exact; it.lat = lat; it.bias = bias;
    sb.push_back(it);
    @(posedge clk); #1;
    in_valid = 0;
    gain_full = ~full;  // a flip between beats must not reach beats in flight (R8)
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(0, "R6", "unexpected output beat", int'(out_i), 0);
        end else begin
          item_t it;
          int di, dq, tl;
          it = sb.pop_front();
          tl = it.exact ? 0 : TOL;
          di = int'(out_i) - it.ei; dq = int'(out_q) - it.eq;
          check(di <= tl && di >= -tl, it.tag, "I", int'(out_i), it.ei);
          check(dq <= tl && dq >= -tl, it.tag, "Q", int'(out_q), it.eq);
          if (it.lat) check(cyc - it.acc == ITER + 1, "R7", "latency", cyc - it.acc, ITER + 1);
          if (it.bias) begin bias_sum += real'(out_i) - it.ri; bias_n++; end
        end
      end else if (out_valid && !out_ready) begin
        logic signed [DW-1:0] hi, hq;
        hi = out_i; hq = out_q;
        @(negedge clk); #1;
        check(out_valid && out_i == hi && out_q == hq, "R6", "hold under stall",
              int'(out_i), int'(hi));
        #0;
        if (out_valid && out_ready) begin
          item_t it;
          int di;
          it = sb.pop_front();
          di = int'(out_i) - it.ei;
          check(di <= TOL && di >= -TOL && int'(out_q) - it.eq <= TOL && it.eq - int'(out_q) <= TOL,
                it.tag, "I after stall", int'(out_i), it.ei);
          if (it.bias) begin bias_sum += real'(out_i) - it.ri; bias_n++; end
        end
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic drain();
    int n = 0;
    while (sb.size() != 0 && n < 2000) begin @(posedge clk); n++; end
    check(sb.size() == 0, "R6", "pipeline drained", sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    kgain = 1.0;
    for (int k = 0; k < ITER; k++) kgain = kgain * $sqrt(1.0 + 2.0 ** (-2.0 * k));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(out_valid == 0, "R9", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1, "R9", "in_ready after reset", int'(in_ready), 1);

    // R7 latency, no stall
    send(10000, 0, 0, 0, "R7", 0, 1);
    drain();

    // R1 full-scale halving at angle zero
    send(16376, 0, 0, 0, "R1");
    send(-16376, 5000, 1234, 0, "R1");
    // R2 no halving
    send(16376, 0, 0, 1, "R2");
    send(8000, -3000, 777, 1, "R2");
    // R4 quadrants, exact axes
    send(12000, 0, 16'h4000, 0, "R4");
    send(12000, 0, 16'h8000, 0, "R4");
    send(12000, 0, 16'hC000, 0, "R4");
    send(0, 9000, 16'h5555, 1, "R4");
    send(7000, -7000, 16'hA000, 1, "R4");
    send(-5000, 3000, 16'hE100, 1, "R4");
    // R3 45 degrees with equal large components
    send(25000, 25000, 16'h2000, 1, "R3");
    send(-25000, -25000, 16'h2000, 1, "R3");
    send(25000, 25000, 16'h2000, 0, "R1");
    send(32767, 32767, 16'hE000, 1, "R3");
    // R5 zero input is exactly zero
    send(0, 0, 16'h1234, 0, "R5", 1);
    send(0, 0, 16'hBEEF, 1, "R5", 1);
    drain();

    // R6/R8 random traffic under back-pressure with mode flips
    stall_en = 1;
    for (int n = 0; n < 200; n++)
      send($urandom_range(0, 40000) - 20000, $urandom_range(0, 40000) - 20000,
           $urandom_range(0, 65535), n[0], "R8");
    drain();
    stall_en = 0;

    // R5 mean error over random samples in halving mode
    for (int n = 0; n < 256; n++)
      send($urandom_range(0, 20000) - 10000, $urandom_range(0, 20000) - 10000,
           $urandom_range(0, 65535), 0, "R5", 0, 0, 1);
    drain();
    begin
      real m;
      m = bias_sum / real'(bias_n);
      check(m < 0.25 && m > -0.25, "R5", "mean error x1000", int'(m * 1000.0), 0);
    end
    finish_up();
  end
endmodule